// File: doc/BRIEF.md
# Texture Fetch with Edge Addressing and Linear Blend

This block is a one-dimensional texture sampler in fixed point. A request carries a texel-space coordinate with a fractional part, plus three mode bits: the addressing rule, the filter, and the texel format. The block finds the two texels around the sample position and applies the addressing rule to each of them separately. It reads both from an internal texel store, turns each raw texel into a signed normalized value, and mixes the two with a weight that depends on how far the sample lies from each texel centre.

Texel centres lie halfway between integer coordinates. A sample that lands exactly on a centre returns that texel alone. A sample on an integer coordinate returns an even mix of its two neighbours. The pipeline takes one request per clock and returns every result after the same fixed delay, so a requester can stream coordinates with no back-pressure. Texels are loaded through a simple write port.

Top module: `tex_fetch_filter`

## Requirements
- R1: While reset is held and after it is released, `out_valid` stays low until a request has been accepted.
- R2: A request sampled by rising edge n gives `out_valid` high from edge n+2 until edge n+3, carrying that request's result. Back-to-back requests give back-to-back results. With no request, `out_valid` is low.
- R3: Nearest filter (`req_linear`=0). The index is the integer part of the coordinate (bits 15:8). The output is that texel's normalized value, with no blending.
- R4: Linear filter (`req_linear`=1). Let d = coordinate − 0.5, with the coordinate unsigned 8.8 fixed point. The taps are floor(d) and floor(d)+1, and the weight w is the fraction of d in units of 1/256. A coordinate of k+0.5 gives w=0, and an integer coordinate gives w=128.
- R5: Clamp addressing (`req_wrap`=0). A tap index below 0 becomes 0, and a tap index above N−1 becomes N−1. N = 2^LOG2_N texels, 64 by default.
- R6: Wrap addressing (`req_wrap`=1). Each tap index is taken modulo N, so index −1 maps to N−1 and index N maps to 0.
- R7: The result is ((256−w)·V0 + w·V1 + 128) >> 8, with an arithmetic shift. V0 and V1 are the normalized tap values.
- R8: Narrow format (`req_wide`=0). Bits 7:0 of the stored texel are a signed 8-bit value v. The result is v·16384/127 rounded to nearest, with ties away from zero, in signed Q2.14. The code −128 gives −16384.
- R9: Wide format (`req_wide`=1). All 16 bits are a signed value v. The result is v·16384/32767 rounded the same way. The code −32768 gives −16384.
- R10: `tex_we` high at a rising edge stores `tex_wdata` at `tex_waddr`. A request sampled at that same edge or later reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tex_we | input | 1 | Texel write enable |
| tex_waddr | input | LOG2_N | Texel write index |
| tex_wdata | input | 16 | Texel write data |
| req_valid | input | 1 | Request present this cycle |
| req_coord | input | 16 | Coordinate, unsigned 8.8 texel units |
| req_wrap | input | 1 | 1 = wrap, 0 = clamp |
| req_linear | input | 1 | 1 = linear blend, 0 = nearest |
| req_wide | input | 1 | 1 = signed 16-bit texel, 0 = signed 8-bit in bits 7:0 |
| out_valid | output | 1 | Result valid |
| out_value | output | 16 | Result, signed Q2.14 |

## Verification
The assertions assume two things: every texel read by an accepted request has been written since power-up, and `req_valid` is low while reset is held. Under those conditions the latency and blend-range checks compare only defined values. The stimulus loads the whole texel store before it issues any request, and it keeps every request input at zero until reset has been released for several cycles. It then covers the full coordinate range, including values far beyond the texture size, the addressing edges, and mid-stream rewrites of the store.

// File: rtl/texf_pkg.sv
`timescale 1ns/1ps
package texf_pkg;
  localparam int TEXEL_W  = 16;
  localparam int NARROW_W = 8;

  typedef enum logic {ADDR_CLAMP = 1'b0, ADDR_WRAP = 1'b1} addr_mode_e;
  typedef enum logic {FILT_NEAREST = 1'b0, FILT_LINEAR = 1'b1} filter_e;
endpackage

// File: rtl/tex_addr_gen.sv
`timescale 1ns/1ps
module tex_addr_gen
  import texf_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8,
  parameter int LOG2_N = 6
) (
  input  logic [INT_W+FRAC_W-1:0]  coord,
  input  addr_mode_e               mode,
  input  filter_e                  filt,
  output logic [1:0][LOG2_N-1:0]   idx,
  output logic [FRAC_W:0]          weight
);
  localparam int CW = INT_W + FRAC_W;
  localparam int SW = CW + 1;
  localparam int BW = INT_W + 2;
  localparam logic signed [BW-1:0] LAST = BW'((1 << LOG2_N) - 1);
  localparam logic [SW-1:0] HALF = SW'(1) << (FRAC_W - 1);

  logic [SW-1:0]          shifted;
  logic signed [BW-1:0]   tap [2];

  function automatic logic [LOG2_N-1:0] fold(input logic signed [BW-1:0] i,
                                             input addr_mode_e m);
    if (m == ADDR_WRAP) return i[LOG2_N-1:0];
    if (i < 0)          return '0;
    if (i > LAST)       return LAST[LOG2_N-1:0];
    return i[LOG2_N-1:0];
  endfunction

  // Tap selection: centre offset of one half in linear mode
  always_comb begin
    shifted = {1'b0, coord} - HALF;
    if (filt == FILT_LINEAR) begin
      tap[0] = {shifted[SW-1], shifted[SW-1:FRAC_W]};
      weight = {1'b0, shifted[FRAC_W-1:0]};
    end else begin
      tap[0] = {2'b00, coord[CW-1:FRAC_W]};
      weight = '0;
    end
    tap[1] = tap[0] + BW'(1);
  end

  for (genvar t = 0; t < 2; t++) begin : g_tap
    assign idx[t] = fold(tap[t], mode);
  end

  always_comb begin
    if (mode == ADDR_CLAMP && tap[0] < 0)
      assert_clamp_floor_R5: assert (idx[0] == '0);
    if (mode == ADDR_CLAMP && tap[1] > LAST)
      assert_clamp_ceiling_R5: assert (idx[1] == LAST[LOG2_N-1:0]);
    if (mode == ADDR_WRAP)
      assert_wrap_adjacent_R6: assert (idx[1] == idx[0] + LOG2_N'(1));
  end
endmodule

// File: rtl/tex_texel_norm.sv
`timescale 1ns/1ps
module tex_texel_norm
  import texf_pkg::*;
#(
  parameter int OUT_FRAC = 14,
  parameter int OUT_W    = 16
) (
  input  logic [TEXEL_W-1:0]       raw,
  input  logic                     wide,
  output logic signed [OUT_W-1:0]  norm_out
);
  localparam logic signed [OUT_W-1:0] ONE = OUT_W'(1) << OUT_FRAC;
  localparam logic [31:0] MAX_N = 32'((1 << (NARROW_W - 1)) - 1);
  localparam logic [31:0] MAX_W = 32'((1 << (TEXEL_W - 1)) - 1);

  logic signed [TEXEL_W-1:0] v;
  logic                      is_min;
  logic [TEXEL_W-1:0]        mag;
  logic [31:0]               num;
  logic [OUT_W-1:0]          q;

  always_comb begin
    if (wide) begin
      v      = raw;
      is_min = (raw == {1'b1, {(TEXEL_W-1){1'b0}}});
    end else begin
      v      = {{(TEXEL_W-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
      is_min = (raw[NARROW_W-1:0] == {1'b1, {(NARROW_W-1){1'b0}}});
    end
    mag = v[TEXEL_W-1] ? TEXEL_W'(-v) : TEXEL_W'(v);
    num = ({16'd0, mag} << (OUT_FRAC + 1)) + (wide ? MAX_W : MAX_N);
    q   = wide ? OUT_W'(num / (MAX_W << 1)) : OUT_W'(num / (MAX_N << 1));
    if (is_min)              norm_out = -ONE;
    else if (v[TEXEL_W-1])   norm_out = -$signed(q);
    else                     norm_out = $signed(q);
  end

  always_comb begin
    assert_norm_range_R8: assert (norm_out <= ONE && norm_out >= -ONE);
    if (v < 0) assert_norm_sign_R9: assert (norm_out <= 0);
    else       assert_norm_sign_pos_R9: assert (norm_out >= 0);
  end
endmodule

// File: rtl/tex_fetch_filter.sv
`timescale 1ns/1ps
module tex_fetch_filter
  import texf_pkg::*;
#(
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 8,
  parameter int LOG2_N   = 6,
  parameter int OUT_FRAC = 14,
  parameter int OUT_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tex_we,
  input  logic [LOG2_N-1:0]         tex_waddr,
  input  logic [15:0]               tex_wdata,
  input  logic                      req_valid,
  input  logic [INT_W+FRAC_W-1:0]   req_coord,
  input  logic                      req_wrap,
  input  logic                      req_linear,
  input  logic                      req_wide,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_value
);
  localparam int N     = 1 << LOG2_N;
  localparam int WW    = FRAC_W + 1;
  localparam int ACC_W = OUT_W + FRAC_W + 3;
  localparam logic [FRAC_W+1:0] FULL = (FRAC_W+2)'(1) << FRAC_W;
  localparam logic signed [ACC_W-1:0] ROUND_C = ACC_W'(1) << (FRAC_W - 1);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  // Texel store
  logic [TEXEL_W-1:0] tex_mem [N];
  always_ff @(posedge clk) begin
    if (tex_we) tex_mem[tex_waddr] <= tex_wdata;
  end

  // Stage 1: tap indices and weight
  logic [1:0][LOG2_N-1:0] idx_nxt, s1_idx;
  logic [WW-1:0]          w_nxt, s1_w;
  logic                   s1_valid, s1_wide;

  tex_addr_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LOG2_N(LOG2_N)) u_addr (
    .coord  (req_coord),
    .mode   (addr_mode_e'(req_wrap)),
    .filt   (filter_e'(req_linear)),
    .idx    (idx_nxt),
    .weight (w_nxt)
  );

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) s1_valid <= 1'b0;
    else          s1_valid <= req_valid;
  end
  always_ff @(posedge clk) begin
    if (req_valid) begin
      s1_idx  <= idx_nxt;
      s1_w    <= w_nxt;
      s1_wide <= req_wide;
    end
  end

  // Stage 2: texel reads
  logic [TEXEL_W-1:0] rd_nxt [2];
  logic [TEXEL_W-1:0] s2_tex [2];
  logic [WW-1:0]      s2_w;
  logic               s2_valid, s2_wide;

  always_comb begin
    for (int t = 0; t < 2; t++) rd_nxt[t] = tex_mem[s1_idx[t]];
  end
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) s2_valid <= 1'b0;
    else          s2_valid <= s1_valid;
  end
  always_ff @(posedge clk) begin
    if (s1_valid) begin
      for (int t = 0; t < 2; t++) s2_tex[t] <= rd_nxt[t];
      s2_w    <= s1_w;
      s2_wide <= s1_wide;
    end
  end

  // Stage 3: normalize and blend
  logic signed [OUT_W-1:0]  tap_norm [2];
  logic signed [FRAC_W+1:0] w_lo, w_hi;
  logic signed [ACC_W-1:0]  acc;
  logic [OUT_W-1:0]         blend_nxt;

  for (genvar t = 0; t < 2; t++) begin : g_norm
    tex_texel_norm #(.OUT_FRAC(OUT_FRAC), .OUT_W(OUT_W)) u_norm (
      .raw      (s2_tex[t]),
      .wide     (s2_wide),
      .norm_out (tap_norm[t])
    );
  end

  always_comb begin
    w_lo      = $signed({1'b0, s2_w});
    w_hi      = $signed(FULL - {1'b0, s2_w});
    acc       = w_hi * tap_norm[0] + w_lo * tap_norm[1] + ROUND_C;
    blend_nxt = OUT_W'(acc >>> FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) out_valid <= 1'b0;
    else          out_valid <= s2_valid;
  end
  always_ff @(posedge clk) begin
    if (s2_valid) out_value <= blend_nxt;
  end

  // Checks
  always_comb begin
    if (s2_valid) begin
      assert_blend_bounds_R7: assert (
        $signed(blend_nxt) >= ((tap_norm[0] < tap_norm[1]) ? tap_norm[0] : tap_norm[1]) &&
        $signed(blend_nxt) <= ((tap_norm[0] > tap_norm[1]) ? tap_norm[0] : tap_norm[1]));
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_int)
    (since_rst == 2'd3) |-> (out_valid == $past(req_valid, 3)));

  assert_nearest_unweighted_R3: assert property (@(posedge clk) disable iff (!rst_int)
    (req_valid && !req_linear) |=> (s1_w == '0));

  assert_weight_span_R4: assert property (@(posedge clk) disable iff (!rst_int)
    s1_valid |-> (s1_w < WW'(FULL)));
endmodule

// File: tb/tb_tex_fetch_filter.sv
`timescale 1ns/1ps
module tb_tex_fetch_filter;
  localparam int LOG2_N = 6;
  localparam int N      = 1 << LOG2_N;

  logic              clk, rst_n;
  logic              tex_we;
  logic [LOG2_N-1:0] tex_waddr;
  logic [15:0]       tex_wdata;
  logic              req_valid;
  logic [15:0]       req_coord;
  logic              req_wrap, req_linear, req_wide;
  logic              out_valid;
  logic [15:0]       out_value;

  tex_fetch_filter #(.LOG2_N(LOG2_N)) dut (
    .clk(clk), .rst_n(rst_n), .tex_we(tex_we), .tex_waddr(tex_waddr),
    .tex_wdata(tex_wdata), .req_valid(req_valid), .req_coord(req_coord),
    .req_wrap(req_wrap), .req_linear(req_linear), .req_wide(req_wide),
    .out_valid(out_valid), .out_value(out_value)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  bit [15:0] tbmem [N];
  bit    pv [3];
  int    pe [3];
  string ptag [3];

  function automatic int ref_fold(int i, bit wrap);
    if (wrap) return ((i % N) + N) % N;
    if (i < 0) return 0;
    if (i > N - 1) return N - 1;
    return i;
  endfunction

  function automatic int ref_norm(bit [15:0] raw, bit wide);
    int v, mx, mag, r;
    if (wide) begin v = $signed(raw); mx = 32767; end
    else begin v = $signed(raw[7:0]); mx = 127; end
    if (v == -mx - 1) return -16384;
    mag = (v < 0) ? -v : v;
    r = (mag * 32768 + mx) / (2 * mx);
    return (v < 0) ? -r : r;
  endfunction

  function automatic int ref_fetch(bit [15:0] c, bit wrap, bit lin, bit wide);
    int d, base, w, n0, n1, acc;
    if (lin) begin
      d = int'(c) - 128;
      base = d >>> 8;
      w = d & 255;
    end else begin
      base = int'(c) >> 8;
      w = 0;
    end
    n0 = ref_norm(tbmem[ref_fold(base, wrap)], wide);
    n1 = ref_norm(tbmem[ref_fold(base + 1, wrap)], wide);
    acc = (256 - w) * n0 + w * n1 + 128;
    return acc >>> 8;
  endfunction

  task automatic step(input string tag, input bit v, input bit [15:0] c,
                      input bit wr, input bit ln, input bit wd,
                      input bit we, input int wa, input bit [15:0] wdat);
    @(negedge clk);
    checks++;
    if (pv[2]) begin
      if (!(out_valid === 1'b1 && int'($signed(out_value)) == pe[2])) begin
        errors++;
        $display("FAIL %s: valid=%0b value=%0d expected valid=1 value=%0d",
                 ptag[2], out_valid, int'($signed(out_value)), pe[2]);
      end
    end else if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: valid=%0b expected valid=0", ptag[2], out_valid);
    end
    pv[2] = pv[1]; pe[2] = pe[1]; ptag[2] = ptag[1];
    pv[1] = pv[0]; pe[1] = pe[0]; ptag[1] = ptag[0];
    if (we) tbmem[wa] = wdat;
    tex_we     = we;
    tex_waddr  = LOG2_N'(wa);
    tex_wdata  = wdat;
    req_valid  = v;
    req_coord  = c;
    req_wrap   = wr;
    req_linear = ln;
    req_wide   = wd;
    pv[0]   = v;
    pe[0]   = v ? ref_fetch(c, wr, ln, wd) : 0;
    ptag[0] = tag;
  endtask

  task automatic req(input string tag, input bit [15:0] c, input bit wr,
                     input bit ln, input bit wd);
    step(tag, 1'b1, c, wr, ln, wd, 1'b0, 0, 16'h0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 16'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin pv[i] = 0; pe[i] = 0; ptag[i] = "R1"; end
    rst_n = 1'b0; tex_we = 1'b0; tex_waddr = '0; tex_wdata = '0;
    req_valid = 1'b0; req_coord = '0; req_wrap = 1'b0; req_linear = 1'b0; req_wide = 1'b0;
    // R1: output idle during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1: valid=%0b expected valid=0 in reset", out_valid);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) idle("R1");

    // R10: load the store, with corner codes at fixed indices
    for (int i = 0; i < N; i++) begin
      bit [15:0] d;
      d = 16'($urandom);
      case (i)
        0:  d = 16'h0040;
        5:  d = 16'h0080;
        6:  d = 16'h8000;
        7:  d = 16'h7FFF;
        8:  d = 16'h007F;
        N - 1: d = 16'hFFC0;
        default: ;
      endcase
      step("R1", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, i, d);
    end
    idle("R1");

    // R3, R8, R9: nearest fetches of the corner codes
    req("R8", 16'h0580, 1'b0, 1'b0, 1'b0);
    req("R9", 16'h0600, 1'b0, 1'b0, 1'b1);
    req("R9", 16'h0700, 1'b0, 1'b0, 1'b1);
    req("R8", 16'h08FF, 1'b0, 1'b0, 1'b0);
    req("R3", 16'h0710, 1'b0, 1'b0, 1'b0);
    req("R9", 16'h0500, 1'b0, 1'b0, 1'b1);
    // R4, R7: centre, midpoint and quarter positions
    req("R4", 16'h0180, 1'b0, 1'b1, 1'b1);
    req("R4", 16'h0200, 1'b0, 1'b1, 1'b1);
    req("R7", 16'h0240, 1'b0, 1'b1, 1'b0);
    req("R7", 16'h0680, 1'b0, 1'b1, 1'b1);
    req("R7", 16'h0600, 1'b0, 1'b1, 1'b0);
    // R5: clamp at both edges
    req("R5", 16'h0000, 1'b0, 1'b1, 1'b0);
    req("R5", 16'hFF00, 1'b0, 1'b1, 1'b0);
    req("R5", 16'h3FC0, 1'b0, 1'b1, 1'b1);
    req("R5", 16'h9000, 1'b0, 1'b0, 1'b0);
    // R6: wrap at both edges
    req("R6", 16'h0000, 1'b1, 1'b1, 1'b0);
    req("R6", 16'h4000, 1'b1, 1'b0, 1'b0);
    req("R6", 16'h3FC0, 1'b1, 1'b1, 1'b0);
    req("R6", 16'hC1C0, 1'b1, 1'b1, 1'b1);
    idle("R2");
    // R10: rewrite with a request at the same edge, then the next edge
    step("R10", 1'b1, 16'h0A00, 1'b0, 1'b0, 1'b1, 1'b1, 10, 16'h4000);
    step("R10", 1'b1, 16'h0A80, 1'b0, 1'b1, 1'b0, 1'b1, 11, 16'h00C0);
    req("R10", 16'h0B00, 1'b0, 1'b1, 1'b0);
    idle("R2");

    // R2: random traffic with gaps and interleaved writes
    for (int i = 0; i < 1500; i++) begin
      bit v, we;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 16) == 0;
      step("R2", v, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           we, int'($urandom % N), 16'($urandom));
    end
    for (int i = 0; i < 4; i++) idle("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule